// File: doc/BRIEF.md
# Mask ROM with Programmable Selects

A read-only memory of 2048 bytes that drives a tri-state byte bus. An 11-bit address picks the word. Three select inputs gate the bus, and a parameter sets each one on its own to be active-low, active-high or ignored. The bus carries data only when every select is in its configured state. At all other times it floats.

The block runs from one clock and models the access delays of a real part as cycle counts. An address change, a select and a deselect each have their own latency. A power-up lockout keeps the bus floating for a set number of cycles after reset. The stored image comes from a parameter, and a load port can overwrite any word. The load port is meant for initialisation only.

Top module: `sel_rom`

## Requirements
- R1: A word written through the load port at address A, with `ld_en` high at a rising edge, is later read back on `dq` when `addr` equals A and the bus is driven. Every one of the 2^AW addresses is reachable, including 0 and 2047.
- R2: Select i uses the 2-bit mode code given by parameter SELi_MODE. Code 0 matches when `cs[i]` is 0. Code 1 matches when `cs[i]` is 1. Codes 2 and 3 always match. The device counts as selected only when all three selects match, and toggling a select whose mode is 2 or 3 has no effect on `oe` or `dq`.
- R3: Whenever `oe` is 0, all bits of `dq` are high-impedance.
- R4: After `addr` takes a new value, `oe` rises with the new word at the ADDR_LAT-th rising edge, counting the edge that first sampled the new value. Any further change restarts this count.
- R5: After the device becomes selected, `oe` rises at the SEL_LAT-th rising edge, counting the first edge that sampled the selected state. If the address latency is still pending, it must also expire first.
- R6: After the device becomes deselected, `dq` keeps driving the same word until the DESEL_LAT-th rising edge, counting the first deselected edge. At that edge `oe` falls.
- R7: `oe` stays 0 until the PWRUP_CYC-th rising edge after reset is released, whatever the state of the other inputs.
- R8: While `oe` is 1, and neither the address nor the stored contents change, `dq` holds its value.
- R9: An address never written through the load port reads the byte that the INIT parameter holds for it. Word k occupies INIT bits [8k+7:8k].
- R10: While `rst_n` is 0, `oe` is 0 and `dq` floats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Read address |
| cs | input | 3 | Programmable select inputs |
| ld_en | input | 1 | Load strobe for the image |
| ld_addr | input | AW | Load address |
| ld_data | input | DW | Load data |
| dq | output | DW | Tri-state data bus |
| oe | output | 1 | High while `dq` is driven |

## Verification
The bench builds the block with the modes active-low, active-high and code 3. This places a level-sensitive match, an inverted match and an ignored input side by side. The latencies are 4 for address, 2 for select and 3 for deselect, so the address and select windows differ. This makes it observable which of the two gates the bus on a combined reselect. The power-up count is 20, which keeps the lockout within reach of the run. The image is a constant 0x5A, so unloaded words can be told apart from loaded ones.

// File: rtl/sel_rom.sv
module sel_rom #(
  parameter int AW = 11,
  parameter int DW = 8,
  parameter logic [1:0] SEL0_MODE = 2'd0,
  parameter logic [1:0] SEL1_MODE = 2'd1,
  parameter logic [1:0] SEL2_MODE = 2'd2,
  parameter int ADDR_LAT = 4,
  parameter int SEL_LAT = 2,
  parameter int DESEL_LAT = 2,
  parameter int PWRUP_CYC = 500000,
  parameter logic [(1<<AW)*DW-1:0] INIT = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [2:0]    cs,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  output logic [DW-1:0] dq,
  output logic          oe
);
  localparam int DEPTH = 1 << AW;
  localparam int AL_W = $clog2(ADDR_LAT + 1);
  localparam int SL_W = $clog2(SEL_LAT + 1);
  localparam int DL_W = $clog2(DESEL_LAT + 1);
  localparam int PW_W = $clog2(PWRUP_CYC + 1);
  localparam logic [AL_W-1:0] A_MAX = AL_W'(ADDR_LAT);
  localparam logic [SL_W-1:0] S_MAX = SL_W'(SEL_LAT);
  localparam logic [DL_W-1:0] D_MAX = DL_W'(DESEL_LAT);
  localparam logic [PW_W-1:0] P_MAX = PW_W'(PWRUP_CYC);
  localparam logic [5:0] MODES = {SEL2_MODE, SEL1_MODE, SEL0_MODE};

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;
  logic [AW-1:0] addr_q;
  logic [AL_W-1:0] a_cnt, a_nx;
  logic [SL_W-1:0] s_cnt, s_nx;
  logic [DL_W-1:0] d_cnt, d_nx;
  logic [PW_W-1:0] p_cnt, p_nx;
  logic [2:0] hit;
  logic sel, drive_nx;

  for (genvar i = 0; i < 3; i++) begin : g_sel
    assign hit[i] = MODES[2*i+1] | (cs[i] == MODES[2*i]);
  end
  assign sel = &hit;

  initial for (int i = 0; i < DEPTH; i++) mem[i] = INIT[i*DW +: DW];

  always_ff @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    rd_q <= mem[addr];
  end

  always_comb begin
    a_nx = (addr != addr_q) ? AL_W'(1) : ((a_cnt == A_MAX) ? a_cnt : a_cnt + 1'b1);
    s_nx = !sel ? '0 : ((s_cnt == S_MAX) ? s_cnt : s_cnt + 1'b1);
    d_nx = sel ? '0 : ((d_cnt == D_MAX) ? d_cnt : d_cnt + 1'b1);
    p_nx = (p_cnt == P_MAX) ? p_cnt : p_cnt + 1'b1;
    drive_nx = (p_nx == P_MAX) &&
               ((sel && s_nx == S_MAX && a_nx == A_MAX) ||
                (!sel && oe && d_nx != D_MAX));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      a_cnt  <= '0;
      s_cnt  <= '0;
      d_cnt  <= '0;
      p_cnt  <= '0;
      oe     <= 1'b0;
    end else begin
      addr_q <= addr;
      a_cnt  <= a_nx;
      s_cnt  <= s_nx;
      d_cnt  <= d_nx;
      p_cnt  <= p_nx;
      oe     <= drive_nx;
    end
  end

  assign dq = oe ? rd_q : {DW{1'bz}};
endmodule

// File: rtl/sel_rom_chk.sv
module sel_rom_chk #(
  parameter int AW = 11,
  parameter int DW = 8,
  parameter logic [1:0] SEL0_MODE = 2'd0,
  parameter logic [1:0] SEL1_MODE = 2'd1,
  parameter logic [1:0] SEL2_MODE = 2'd2,
  parameter int ADDR_LAT = 4,
  parameter int SEL_LAT = 2,
  parameter int DESEL_LAT = 2,
  parameter int PWRUP_CYC = 500000
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic [2:0]    cs,
  input logic          ld_en,
  input logic [DW-1:0] dq,
  input logic          oe
);
  function automatic logic ok(input logic [1:0] m, input logic c);
    return (m >= 2'd2) || (c == m[0]);
  endfunction

  logic match;
  int pcnt, scnt, dcnt;
  assign match = ok(SEL0_MODE, cs[0]) && ok(SEL1_MODE, cs[1]) && ok(SEL2_MODE, cs[2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= 0; scnt <= 0; dcnt <= 0;
    end else begin
      if (pcnt < PWRUP_CYC) pcnt <= pcnt + 1;
      scnt <= !match ? 0 : ((scnt < SEL_LAT) ? scnt + 1 : scnt);
      dcnt <= match ? 0 : ((dcnt < DESEL_LAT) ? dcnt + 1 : dcnt);
    end
  end

  AST_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (pcnt < PWRUP_CYC) |-> !oe); // R7
  AST_SEL_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> ((scnt >= SEL_LAT) || (dcnt > 0 && dcnt < DESEL_LAT))); // R5
  AST_DESEL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (dcnt >= DESEL_LAT) |-> !oe); // R6
  AST_ADDR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (ADDR_LAT > 1 && addr != $past(addr)) |=> !oe); // R4
  AST_SEL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> $past(match)); // R2
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && $past(oe) && $past(addr) == $past(addr, 2) && !$past(ld_en) && !$past(ld_en, 2))
    |-> $stable(dq)); // R8
  AST_RESET_OFF: assert property (@(posedge clk) !rst_n |-> !oe); // R10
endmodule

bind sel_rom sel_rom_chk #(
  .AW(AW), .DW(DW), .SEL0_MODE(SEL0_MODE), .SEL1_MODE(SEL1_MODE), .SEL2_MODE(SEL2_MODE),
  .ADDR_LAT(ADDR_LAT), .SEL_LAT(SEL_LAT), .DESEL_LAT(DESEL_LAT), .PWRUP_CYC(PWRUP_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .cs(cs), .ld_en(ld_en), .dq(dq), .oe(oe)
);

// File: tb/sel_rom_tb.sv
module sel_rom_tb;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam int AL = 4, SL = 2, DL = 3, PW = 20;
  localparam logic [2:0] SEL_ON = 3'b010;

  typedef struct {
    logic          z_e;
    logic [DW-1:0] d_e;
    string         tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [2:0] cs = 3'b001;
  logic ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;
  wire  [DW-1:0] dq;
  wire           oe;

  int checks = 0, fails = 0;
  bit done = 0;
  item_t q[$];

  always #2 clk = ~clk;

  sel_rom #(
    .AW(AW), .DW(DW), .SEL0_MODE(2'd0), .SEL1_MODE(2'd1), .SEL2_MODE(2'd3),
    .ADDR_LAT(AL), .SEL_LAT(SL), .DESEL_LAT(DL), .PWRUP_CYC(PW),
    .INIT({2048{8'h5A}})
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cs(cs), .ld_en(ld_en),
    .ld_addr(ld_addr), .ld_data(ld_data), .dq(dq), .oe(oe)
  );

  function automatic logic [7:0] f(input int a);
    return 8'(a * 37 + 11);
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic exp_z(input string tag);
    item_t it;
    it.z_e = 1'b1; it.d_e = '0; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic exp_d(input logic [7:0] d, input string tag);
    item_t it;
    it.z_e = 1'b0; it.d_e = d; it.tag = tag;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    #1;
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (it.z_e) begin
        if (oe !== 1'b0 || dq !== 8'hzz) begin
          fails++;
          $display("FAIL %s: oe=%b dq=%h expected oe=0 dq=zz", it.tag, oe, dq);
        end
      end else if (oe !== 1'b1 || dq !== it.d_e) begin
        fails++;
        $display("FAIL %s: oe=%b dq=%h expected oe=1 dq=%h", it.tag, oe, dq, it.d_e);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    exp_z("R10");
    step(1);
    // release reset, select at once, load image during the lockout
    rst_n = 1'b1; cs = SEL_ON; addr = 11'd5;
    for (int i = 0; i < 17; i++) begin
      ld_en = 1'b1;
      ld_addr = (i == 16) ? 11'd2047 : 11'(i);
      ld_data = (i == 16) ? f(2047) : f(i);
      step(1);
    end
    ld_en = 1'b0;
    step(2);
    exp_z("R7");
    step(1);
    exp_d(f(5), "R7");
    // address latency
    addr = 11'd7;
    step(AL - 1); exp_z("R4");
    step(1);      exp_d(f(7), "R4");
    // restart on a second change
    addr = 11'd9;
    step(2);
    addr = 11'd3;
    step(AL - 1); exp_z("R4");
    step(1);      exp_d(f(3), "R1");
    for (int i = 0; i < 3; i++) begin
      step(1); exp_d(f(3), "R8");
    end
    addr = 11'd2047;
    step(AL); exp_d(f(2047), "R1");
    addr = 11'd0;
    step(AL); exp_d(f(0), "R1");
    addr = 11'd100;
    step(AL); exp_d(8'h5A, "R9");
    // ignored select toggling while selected
    for (int i = 0; i < 3; i++) begin
      cs[2] = ~cs[2];
      step(1); exp_d(8'h5A, "R2");
    end
    // deselect through the active-low select
    cs[0] = 1'b1;
    step(DL - 1); exp_d(8'h5A, "R6");
    step(1);      exp_z("R3");
    for (int i = 0; i < 2; i++) begin
      cs[2] = ~cs[2];
      step(1); exp_z("R2");
    end
    // reselect without address change
    cs = SEL_ON;
    step(SL - 1); exp_z("R5");
    step(1);      exp_d(8'h5A, "R5");
    // deselect through the active-high select
    cs[1] = 1'b0;
    step(DL); exp_z("R2");
    // reselect together with a new address
    cs = SEL_ON; addr = 11'd11;
    step(SL); exp_z("R5");
    step(AL - SL); exp_d(f(11), "R5");
    step(3);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule